// File: doc/BRIEF.md
# Decrementer Timer with Coalescing Interrupt Request

This block is a software-visible down-counter that raises an interrupt request when it wraps. Software can load the counter at any time and read the current value on `count_o`. Each cycle in which the timebase strobe `tick_i` is high, the count drops by one. When the counter steps from zero to all ones, a pending flag is set. Any further wraps that happen before the request is serviced merge into that same flag.

The pending request is offered to the core when three conditions hold: external interrupts are enabled, no higher-priority exception is waiting, and the core's arbitration grants it through `ack_i`. In that cycle the request is consumed. One cycle later the block pulses `take_o` and presents the handler address on `vector_o`. The handler address is offset 0x900 from one of two bases, and `ip_i` selects which base. Every pin is a plain control or status signal. There is no streamed data, so no valid/ready handshake and no back-pressure are involved.

Top module: `decr_irq_timer`

## Requirements
- R1: After reset, `count_o` is all ones, and `pending_o` and `take_o` are 0.
- R2: A cycle with `tick_i`=1 and `wr_en_i`=0 lowers the count by one. A cycle with neither input high leaves the count unchanged.
- R3: `wr_en_i`=1 loads `wr_data_i` into the counter at the next edge. This takes priority over a tick in the same cycle.
- R4: A tick taken while the count is zero wraps the counter to all ones, which is the most significant bit going from 0 to 1. `pending_o` is 1 from that same edge.
- R5: A software write never sets `pending_o`. This holds even when the written value has its most significant bit set, and even when it overrides a tick at count zero.
- R6: Any number of wraps that occur before service leave a single pending request, and that request yields exactly one `take_o` pulse.
- R7: A grant happens when `pending_o`, `ee_i` and `ack_i` are all 1 and `hi_pend_i` is 0. A grant clears `pending_o` at the next edge, and `take_o` is 1 for exactly the cycle after the grant.
- R8: While `ee_i`=0, `hi_pend_i`=1 or `ack_i`=0, no `take_o` is produced and `pending_o` stays set.
- R9: When `take_o`=1, `vector_o` is 0xFFF00900 if `ip_i` was 1 in the grant cycle, and 0x00000900 if it was 0.
- R10: When a wrap and a grant fall in the same cycle, `pending_o` remains 1 after the edge, so the new wrap is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe; decrement this cycle |
| wr_en_i | input | 1 | Software load strobe |
| wr_data_i | input | WIDTH | Value to load |
| ee_i | input | 1 | External-interrupt enable |
| hi_pend_i | input | 1 | A higher-priority exception is waiting |
| ip_i | input | 1 | Vector base select (1 = high base) |
| ack_i | input | 1 | Core arbitration accepts this request |
| count_o | output | WIDTH | Current counter value |
| pending_o | output | 1 | Interrupt request pending |
| take_o | output | 1 | One-cycle exception-taken pulse |
| vector_o | output | ADDR_W | Handler address, valid with `take_o` |

## Verification
The hardest state to reach from the ports is a wrap that lands in the same cycle as a grant. A close second is a second wrap arriving while the first request is still outstanding. The bench builds the timer with an 8-bit counter, so a full period is only 256 ticks. It sweeps every load value through to its wrap, and it holds the enable low across a further full period to stack wraps. It then loads zero and applies a tick and a grant on the same edge to hit the coincident case.

// File: rtl/decr_irq_pkg.sv
package decr_irq_pkg;
  localparam logic [31:0] VEC_OFFSET = 32'h0000_0900;
  localparam logic [31:0] BASE_HIGH  = 32'hFFF0_0000;
  localparam logic [31:0] BASE_LOW   = 32'h0000_0000;

  typedef struct packed {
    logic wrap;
    logic load;
  } cnt_evt_t;
endpackage

// File: rtl/decr_count.sv
module decr_count
  import decr_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output cnt_evt_t         evt_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  cnt_evt_t evt;

  always_comb begin
    cnt_d    = cnt_q;
    evt.wrap = 1'b0;
    evt.load = 1'b0;
    if (wr_en_i) begin
      cnt_d    = wr_data_i;
      evt.load = 1'b1;
    end else if (tick_i) begin
      cnt_d    = cnt_q - 1'b1;
      evt.wrap = ~cnt_q[MSB] & cnt_d[MSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign evt_o   = evt;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(count_o));
  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (count_o == $past(wr_data_i)));
endmodule

// File: rtl/decr_pend.sv
module decr_pend
  import decr_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cnt_evt_t evt_i,
  input  logic     ee_i,
  input  logic     hi_pend_i,
  input  logic     ack_i,
  output logic     pending_o,
  output logic     grant_o
);
  logic pend_q;
  logic grant;

  assign grant = pend_q & ee_i & ~hi_pend_i & ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~grant) | evt_i.wrap;
  end

  assign pending_o = pend_q;
  assign grant_o   = grant;

  // R8
  held_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (!ee_i || hi_pend_i || !ack_i)) |=> pend_q);
  // R5
  load_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.load && !pend_q) |=> !pend_q);
  // R10
  wrap_survives_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && evt_i.wrap) |=> pend_q);
endmodule

// File: rtl/decr_vector.sv
module decr_vector
  import decr_irq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic              ip_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o
);
  localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(BASE_HIGH | VEC_OFFSET);
  localparam logic [ADDR_W-1:0] VEC_LO = ADDR_W'(BASE_LOW | VEC_OFFSET);

  logic              take_q;
  logic [ADDR_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= grant_i;
      if (grant_i) vec_q <= ip_i ? VEC_HI : VEC_LO;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;

  // R9
  vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vector_o == ($past(ip_i) ? VEC_HI : VEC_LO)));
endmodule

// File: rtl/decr_irq_timer.sv
module decr_irq_timer
  import decr_irq_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic              ee_i,
  input  logic              hi_pend_i,
  input  logic              ip_i,
  input  logic              ack_i,
  output logic [WIDTH-1:0]  count_o,
  output logic              pending_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o
);
  cnt_evt_t evt;
  logic     grant;

  decr_count #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .evt_o(evt)
  );

  decr_pend u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ee_i(ee_i),
    .hi_pend_i(hi_pend_i), .ack_i(ack_i),
    .pending_o(pending_o), .grant_o(grant)
  );

  decr_vector #(.ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .grant_i(grant), .ip_i(ip_i),
    .take_o(take_o), .vector_o(vector_o)
  );

  // R4
  wrap_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wrap |=> (pending_o && count_o == '1));
  // R7
  take_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(pending_o && ee_i && !hi_pend_i && ack_i));
  // R7
  grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !evt.wrap) |=> !pending_o);
endmodule

// File: tb/decr_irq_timer_bench.sv
module decr_irq_timer_bench;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, wr = 0, ee = 0, hi = 0, ip = 0, ack = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] count;
  logic pending, take;
  logic [31:0] vector;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  decr_irq_timer #(.WIDTH(W), .ADDR_W(32)) u_decr_irq_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr), .wr_data_i(wdata),
    .ee_i(ee), .hi_pend_i(hi), .ip_i(ip), .ack_i(ack),
    .count_o(count), .pending_o(pending), .take_o(take), .vector_o(vector)
  );

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(logic [W-1:0] v);
    wr = 1; wdata = v; step(); wr = 0;
  endtask

  task automatic serve(logic sel);
    ee = 1; ack = 1; hi = 0; ip = sel;
    step();
    ee = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R1 reset state
    expect_eq("R1 count", 32'(count), 32'(ONES));
    expect_eq("R1 pending", 32'(pending), 0);
    expect_eq("R1 take", 32'(take), 0);

    // R2 idle hold
    step();
    expect_eq("R2 idle", 32'(count), 32'(ONES));

    // R2/R4 sweep of every load value through its wrap
    for (int v = 0; v < 256; v++) begin
      load(W'(v));
      expect_eq("R3 load", 32'(count), 32'(v));
      tick = 1;
      for (int k = 1; k <= v; k++) begin
        step();
        expect_eq("R2 dec", 32'(count), 32'(v - k));
      end
      expect_eq("R4 no early request", 32'(pending), 0);
      step();
      tick = 0;
      expect_eq("R4 wrap count", 32'(count), 32'(ONES));
      expect_eq("R4 wrap pending", 32'(pending), 1);
      serve(0);
      expect_eq("R7 take", 32'(take), 1);
      expect_eq("R7 cleared", 32'(pending), 0);
      step();
      expect_eq("R7 one pulse", 32'(take), 0);
    end

    // R3 write beats tick; R5 write with MSB set raises nothing
    load(8'h10);
    tick = 1; wr = 1; wdata = 8'h80; step(); wr = 0; tick = 0;
    expect_eq("R3 priority", 32'(count), 32'h80);
    expect_eq("R5 msb write", 32'(pending), 0);
    load(8'h00);
    tick = 1; wr = 1; wdata = 8'hFF; step(); wr = 0; tick = 0;
    expect_eq("R5 override at zero", 32'(count), 32'hFF);
    expect_eq("R5 no request", 32'(pending), 0);

    // R6 coalescing: three wraps, one take
    load(8'h00);
    tick = 1;
    repeat (1 + 2 * 256) step();
    tick = 0;
    expect_eq("R6 pending", 32'(pending), 1);
    begin
      int takes = 0;
      ee = 1; ack = 1;
      for (int c = 0; c < 4; c++) begin
        step();
        if (take) takes++;
      end
      ee = 0; ack = 0;
      expect_eq("R6 single take", 32'(takes), 1);
    end

    // R8 gating
    load(8'h00); tick = 1; step(); tick = 0;
    ee = 0; ack = 1; step();
    expect_eq("R8 ee low take", 32'(take), 0);
    ee = 1; hi = 1; step();
    expect_eq("R8 hi pend take", 32'(take), 0);
    hi = 0; ack = 0; step();
    expect_eq("R8 no ack take", 32'(take), 0);
    expect_eq("R8 held", 32'(pending), 1);
    ee = 0;

    // R9 vector selection
    serve(1);
    expect_eq("R9 high take", 32'(take), 1);
    expect_eq("R9 high vector", vector, 32'hFFF00900);
    load(8'h00); tick = 1; step(); tick = 0;
    serve(0);
    expect_eq("R9 low vector", vector, 32'h00000900);

    // R10 wrap coincides with grant
    load(8'h00); tick = 1; step();
    expect_eq("R10 setup", 32'(pending), 1);
    load(8'h00);
    tick = 1; ee = 1; ack = 1; step(); tick = 0; ee = 0; ack = 0;
    expect_eq("R10 take", 32'(take), 1);
    expect_eq("R10 still pending", 32'(pending), 1);
    step();
    expect_eq("R10 pulse ends", 32'(take), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule